// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block sits between the instruction fetch unit and the memory of a small 16-bit real-mode processor. Before each instruction fetch it decides whether a latched interrupt may be taken. When one is taken, the block saves the machine state on the stack and jumps through the vector table in low memory. Instruction decode and execution stay outside it. It also holds a halt state that stops all further fetches.

The block keeps the FLAGS, CS, IP and SP registers and shows them on output ports. While no entry is running, the core loads them through a plain load port. The stack segment comes in on its own input. Every memory access goes out on a valid/ready request port. Once `mem_valid` is high, the address, the write enable and the write data stay frozen until the cycle in which `mem_ready` is also high. That cycle completes the access, and read data is taken in it. The memory side applies back-pressure by holding `mem_ready` low for as long as it needs. The sequence never drops or reorders a request. The fetch unit asks with `fetch_req` and may fetch only in a cycle where `fetch_grant` is high.

Top module: `rm_irq_entry`

## Requirements
- R1: After reset, FLAGS, CS, IP and SP read zero. `mem_valid`, `entry_done` and `halted` are low, and `fetch_grant` follows `fetch_req`.
- R2: A pulse on `irq_raise` latches `irq_vec` and a pending flag. A later pulse before the entry starts replaces the latched vector, and the entry then uses the most recent vector.
- R3: An accepted entry makes exactly five accesses in this order: write FLAGS, write CS, read the new CS from offset vec*4+2, write the old IP, read the new IP from offset vec*4. SP falls by 2 before each of the three writes, and each write goes to SS:SP. SP therefore ends 6 lower than it started.
- R4: The FLAGS image written to the stack is the value from before the entry. Once that write completes, bit 9 (interrupt enable) and bit 8 (trap) are cleared, and all other bits are kept.
- R5: A pending vector other than 0 or 2 is taken only while FLAGS bit 9 is 1. Otherwise it stays pending, `fetch_grant` keeps following `fetch_req`, and the entry starts once bit 9 is loaded as 1. Vectors 0 and 2 are taken whatever bit 9 holds.
- R6: Starting an entry clears the pending flag, so one raise produces exactly one entry.
- R7: A pulse on `halt_req` sets `halted` until reset. While `halted` is high, no entry starts and `fetch_grant` stays low.
- R8: The physical address is segment*16 + offset, modulo 2^20. Stack accesses use SS. Vector reads use segment 0. The SP arithmetic wraps modulo 2^16.
- R9: While `mem_valid` is high and `mem_ready` is low, the request does not change and the sequence does not advance.
- R10: `entry_done` is a single-cycle pulse. It is high in the first cycle in which IP and CS hold the values read from the table. `fetch_grant` is never high while a request is outstanding.
- R11: A `ld_en` pulse during an entry is ignored, and the saved values and the final registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_raise | input | 1 | Pulse: latch `irq_vec` as pending |
| irq_vec | input | 8 | Vector number to latch |
| halt_req | input | 1 | Pulse: enter the halted state |
| fetch_req | input | 1 | Fetch unit wants to fetch |
| fetch_grant | output | 1 | Fetch may proceed this cycle |
| entry_done | output | 1 | Pulse: entry finished, new CS:IP valid |
| halted | output | 1 | Halted state |
| ld_en | input | 1 | Load the four registers (honoured when idle) |
| ld_flags | input | 16 | FLAGS load value |
| ld_cs | input | 16 | CS load value |
| ld_ip | input | 16 | IP load value |
| ld_sp | input | 16 | SP load value |
| ss_i | input | 16 | Stack segment |
| flags_o | output | 16 | FLAGS |
| cs_o | output | 16 | CS |
| ip_o | output | 16 | IP |
| sp_o | output | 16 | SP |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts/completes request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, taken in the handshake cycle |

## Verification
The hardest states to reach from the ports are a vector that is latched but blocked by bit 9, and that same vector being replaced before the block lets it in. The bench clears bit 9, raises one vector and then a second. It then shows that no request appears and that fetches are still granted. Finally it loads bit 9 as 1 and checks that the table addresses match the second vector. The wrap corners are covered by a sweep of all 256 vectors with a varying memory latency: SP starting at zero and SS at 0xFFFF, where the physical address passes 2^20.

// File: rtl/rmie_pkg.sv
package rmie_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_FL,
    ST_PUSH_CS,
    ST_READ_CS,
    ST_PUSH_IP,
    ST_READ_IP
  } rmie_state_e;

  localparam int unsigned FLAG_TRAP_BIT  = 8;
  localparam int unsigned FLAG_INTEN_BIT = 9;
endpackage

// File: rtl/rmie_req_latch.sv
module rmie_req_latch #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raise,
  input  logic [VEC_W-1:0] raise_vec,
  input  logic             halt_req,
  input  logic             accept,
  output logic             pending,
  output logic [VEC_W-1:0] vec,
  output logic             halted
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      vec     <= '0;
      halted  <= 1'b0;
    end else begin
      if (raise) begin
        pending <= 1'b1;
        vec     <= raise_vec;
      end else if (accept) begin
        pending <= 1'b0;
      end
      if (halt_req) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/rmie_addr_gen.sv
module rmie_addr_gen
  import rmie_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned SHIFT  = 4
) (
  input  rmie_state_e               state,
  input  logic [WORD_W-1:0]         ss,
  input  logic [WORD_W-1:0]         sp,
  input  logic [VEC_W-1:0]          vec,
  output logic [WORD_W+SHIFT-1:0]   addr,
  output logic                      we
);
  localparam int unsigned ADDR_W = WORD_W + SHIFT;

  logic [WORD_W-1:0] seg, off, push_off, vec_off;

  assign push_off = sp - WORD_W'(2);
  assign vec_off  = WORD_W'({vec, 2'b00});

  always_comb begin
    seg = '0;
    off = '0;
    we  = 1'b0;
    case (state)
      ST_PUSH_FL, ST_PUSH_CS, ST_PUSH_IP: begin
        seg = ss;
        off = push_off;
        we  = 1'b1;
      end
      ST_READ_CS: off = vec_off + WORD_W'(2);
      ST_READ_IP: off = vec_off;
      default: ;
    endcase
  end

  assign addr = {seg, {SHIFT{1'b0}}} + ADDR_W'(off);
endmodule

// File: rtl/rmie_seq.sv
module rmie_seq
  import rmie_pkg::*;
#(
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned VEC_W        = 8,
  parameter int unsigned VEC_BYPASS_A = 0,
  parameter int unsigned VEC_BYPASS_B = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending,
  input  logic [VEC_W-1:0]  vec,
  input  logic              halted,
  output logic              accept,
  output logic [VEC_W-1:0]  active_vec,
  output rmie_state_e       state,
  input  logic              fetch_req,
  output logic              fetch_grant,
  output logic              entry_done,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] ld_flags,
  input  logic [WORD_W-1:0] ld_cs,
  input  logic [WORD_W-1:0] ld_ip,
  input  logic [WORD_W-1:0] ld_sp,
  output logic [WORD_W-1:0] flags_q,
  output logic [WORD_W-1:0] cs_q,
  output logic [WORD_W-1:0] ip_q,
  output logic [WORD_W-1:0] sp_q,
  output logic              mem_valid,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_wdata
);
  localparam logic [WORD_W-1:0] IFTF_MASK =
    (WORD_W'(1) << FLAG_INTEN_BIT) | (WORD_W'(1) << FLAG_TRAP_BIT);

  logic idle, bypass, xfer;

  assign idle        = (state == ST_IDLE);
  assign bypass      = (vec == VEC_W'(VEC_BYPASS_A)) || (vec == VEC_W'(VEC_BYPASS_B));
  assign accept      = idle && pending && !halted && (bypass || flags_q[FLAG_INTEN_BIT]);
  assign fetch_grant = idle && fetch_req && !halted && !accept;
  assign mem_valid   = !idle;
  assign xfer        = mem_valid && mem_ready;

  always_comb begin
    case (state)
      ST_PUSH_FL: mem_wdata = flags_q;
      ST_PUSH_CS: mem_wdata = cs_q;
      ST_PUSH_IP: mem_wdata = ip_q;
      default:    mem_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      active_vec <= '0;
      entry_done <= 1'b0;
      flags_q    <= '0;
      cs_q       <= '0;
      ip_q       <= '0;
      sp_q       <= '0;
    end else begin
      entry_done <= 1'b0;
      if (idle) begin
        if (ld_en) begin
          flags_q <= ld_flags;
          cs_q    <= ld_cs;
          ip_q    <= ld_ip;
          sp_q    <= ld_sp;
        end
        if (accept) begin
          active_vec <= vec;
          state      <= ST_PUSH_FL;
        end
      end else if (xfer) begin
        case (state)
          ST_PUSH_FL: begin
            sp_q    <= sp_q - WORD_W'(2);
            flags_q <= flags_q & ~IFTF_MASK;
            state   <= ST_PUSH_CS;
          end
          ST_PUSH_CS: begin
            sp_q  <= sp_q - WORD_W'(2);
            state <= ST_READ_CS;
          end
          ST_READ_CS: begin
            cs_q  <= mem_rdata;
            state <= ST_PUSH_IP;
          end
          ST_PUSH_IP: begin
            sp_q  <= sp_q - WORD_W'(2);
            state <= ST_READ_IP;
          end
          ST_READ_IP: begin
            ip_q       <= mem_rdata;
            entry_done <= 1'b1;
            state      <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rm_irq_entry.sv
module rm_irq_entry
  import rmie_pkg::*;
#(
  parameter int unsigned WORD_W       = 16,
  parameter int unsigned VEC_W        = 8,
  parameter int unsigned SHIFT        = 4,
  parameter int unsigned VEC_BYPASS_A = 0,
  parameter int unsigned VEC_BYPASS_B = 2,
  localparam int unsigned ADDR_W      = WORD_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_raise,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic              halt_req,
  input  logic              fetch_req,
  output logic              fetch_grant,
  output logic              entry_done,
  output logic              halted,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] ld_flags,
  input  logic [WORD_W-1:0] ld_cs,
  input  logic [WORD_W-1:0] ld_ip,
  input  logic [WORD_W-1:0] ld_sp,
  input  logic [WORD_W-1:0] ss_i,
  output logic [WORD_W-1:0] flags_o,
  output logic [WORD_W-1:0] cs_o,
  output logic [WORD_W-1:0] ip_o,
  output logic [WORD_W-1:0] sp_o,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  logic             pending, accept;
  logic [VEC_W-1:0] latched_vec, active_vec;
  rmie_state_e      state;

  rmie_req_latch #(.VEC_W(VEC_W)) u_req (
    .clk(clk), .rst_n(rst_n), .raise(irq_raise), .raise_vec(irq_vec),
    .halt_req(halt_req), .accept(accept), .pending(pending),
    .vec(latched_vec), .halted(halted)
  );

  rmie_seq #(
    .WORD_W(WORD_W), .VEC_W(VEC_W),
    .VEC_BYPASS_A(VEC_BYPASS_A), .VEC_BYPASS_B(VEC_BYPASS_B)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pending(pending), .vec(latched_vec),
    .halted(halted), .accept(accept), .active_vec(active_vec), .state(state),
    .fetch_req(fetch_req), .fetch_grant(fetch_grant), .entry_done(entry_done),
    .ld_en(ld_en), .ld_flags(ld_flags), .ld_cs(ld_cs), .ld_ip(ld_ip), .ld_sp(ld_sp),
    .flags_q(flags_o), .cs_q(cs_o), .ip_q(ip_o), .sp_q(sp_o),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata)
  );

  rmie_addr_gen #(.WORD_W(WORD_W), .VEC_W(VEC_W), .SHIFT(SHIFT)) u_addr (
    .state(state), .ss(ss_i), .sp(sp_o), .vec(active_vec),
    .addr(mem_addr), .we(mem_we)
  );
endmodule

// File: rtl/rmie_checker.sv
module rmie_checker
  import rmie_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              fetch_grant,
  input logic              halted,
  input logic              entry_done,
  input logic [WORD_W-1:0] flags_o,
  input logic [WORD_W-1:0] sp_o
);
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata))); // R9

  AST_PUSH_STEPS_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_we) |=> (sp_o == $past(sp_o) - WORD_W'(2))); // R3

  AST_ENTRY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> (!flags_o[FLAG_INTEN_BIT] && !flags_o[FLAG_TRAP_BIT])); // R4

  AST_HALT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !fetch_grant); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |=> !entry_done); // R10

  AST_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_grant |-> !mem_valid); // R10
endmodule

bind rm_irq_entry rmie_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .fetch_grant(fetch_grant), .halted(halted), .entry_done(entry_done),
  .flags_o(flags_o), .sp_o(sp_o)
);

// File: tb/rm_irq_entry_test.sv
module rm_irq_entry_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_raise = 1'b0, halt_req = 1'b0, fetch_req = 1'b1, ld_en = 1'b0;
  logic [7:0]  irq_vec = '0;
  logic [15:0] ld_flags = '0, ld_cs = '0, ld_ip = '0, ld_sp = '0, ss_i = '0;
  logic        fetch_grant, entry_done, halted, mem_valid, mem_we;
  logic        mem_ready = 1'b0;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = '0;
  logic [15:0] flags_o, cs_o, ip_o, sp_o;

  int checks = 0, fails = 0;
  int lat = 0, waitcnt = 0, stall_err = 0, grant_err = 0, log_n = 0;
  logic [19:0] first_addr;
  logic        first_we;
  logic [19:0] log_addr [8];
  logic        log_we   [8];
  logic [15:0] log_wd   [8];
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  rm_irq_entry uut (
    .clk(clk), .rst_n(rst_n), .irq_raise(irq_raise), .irq_vec(irq_vec),
    .halt_req(halt_req), .fetch_req(fetch_req), .fetch_grant(fetch_grant),
    .entry_done(entry_done), .halted(halted), .ld_en(ld_en), .ld_flags(ld_flags),
    .ld_cs(ld_cs), .ld_ip(ld_ip), .ld_sp(ld_sp), .ss_i(ss_i), .flags_o(flags_o),
    .cs_o(cs_o), .ip_o(ip_o), .sp_o(sp_o), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] rd_model(input logic [19:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC3A5 ^ {12'h000, a[19:16]};
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: ready after 'lat' waiting cycles, logs each access
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      waitcnt = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_valid) begin
      if (waitcnt == 0) begin
        first_addr = mem_addr;
        first_we   = mem_we;
      end else if (mem_addr !== first_addr || mem_we !== first_we) begin
        stall_err++;
      end
      if (waitcnt >= lat) begin
        if (log_n < 8) begin
          log_addr[log_n] = mem_addr;
          log_we[log_n]   = mem_we;
          log_wd[log_n]   = mem_wdata;
        end
        log_n++;
        mem_rdata = rd_model(mem_addr);
        mem_ready = 1'b1;
        waitcnt = 0;
      end else begin
        waitcnt++;
      end
    end
  end

  task automatic load_regs(input logic [15:0] f, c, i, s);
    @(negedge clk);
    ld_en = 1'b1; ld_flags = f; ld_cs = c; ld_ip = i; ld_sp = s;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic raise(input logic [7:0] v);
    @(negedge clk);
    irq_raise = 1'b1; irq_vec = v;
    @(negedge clk);
    irq_raise = 1'b0;
  endtask

  task automatic wait_done(input bit poke, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400 && !ok; i++) begin
      @(negedge clk);
      if (mem_valid && fetch_grant) grant_err++;
      if (entry_done) ok = 1'b1;
      else if (poke && i == 3) begin
        ld_en = 1'b1; ld_flags = 16'hFFFF; ld_cs = 16'h1111;
        ld_ip = 16'h2222; ld_sp = 16'h3333;
      end else ld_en = 1'b0;
    end
    ld_en = 1'b0;
  endtask

  task automatic check_entry(input logic [7:0] v, input logic [15:0] f, c, i, s, ss,
                             input string tag);
    logic [19:0] ea [5];
    logic        ew [5];
    logic [15:0] ed [5];
    ea[0] = phys(ss, s - 16'd2); ew[0] = 1'b1; ed[0] = f;
    ea[1] = phys(ss, s - 16'd4); ew[1] = 1'b1; ed[1] = c;
    ea[2] = {10'h000, v, 2'b10}; ew[2] = 1'b0; ed[2] = 16'h0;
    ea[3] = phys(ss, s - 16'd6); ew[3] = 1'b1; ed[3] = i;
    ea[4] = {10'h000, v, 2'b00}; ew[4] = 1'b0; ed[4] = 16'h0;
    check(log_n == 5, {tag, " R3 access count"}, log_n, 5);
    for (int k = 0; k < 5; k++) begin
      check(log_addr[k] === ea[k] && log_we[k] === ew[k] &&
            (!ew[k] || log_wd[k] === ed[k]),
            {tag, " R3 R8 access order/address/data"},
            {log_we[k], 11'h0, log_addr[k]}, {ew[k], 11'h0, ea[k]});
    end
    check(cs_o === rd_model(ea[2]), {tag, " R10 new CS"}, cs_o, rd_model(ea[2]));
    check(ip_o === rd_model(ea[4]), {tag, " R10 new IP"}, ip_o, rd_model(ea[4]));
    check(flags_o === (f & ~16'h0300), {tag, " R4 flags after entry"}, flags_o,
          f & ~16'h0300);
    check(sp_o === s - 16'd6, {tag, " R3 final SP"}, sp_o, s - 16'd6);
    @(negedge clk);
    check(entry_done === 1'b0, {tag, " R10 done is one cycle"}, entry_done, 0);
  endtask

  task automatic run_entry(input logic [7:0] v, input logic [15:0] f, c, i, s, ss,
                           input int l, input bit poke, input string tag);
    bit ok;
    ss_i = ss; lat = l;
    load_regs(f, c, i, s);
    log_n = 0;
    raise(v);
    wait_done(poke, ok);
    check(ok, {tag, " R3 entry completes"}, ok, 1);
    if (ok) check_entry(v, f, c, i, s, ss, tag);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    int busy;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(flags_o == 0 && cs_o == 0 && ip_o == 0 && sp_o == 0, "R1 registers zero",
          {flags_o, cs_o}, 0);
    check(!mem_valid && !entry_done && !halted, "R1 control outputs low",
          {mem_valid, entry_done, halted}, 0);
    check(fetch_grant === 1'b1, "R1 grant follows request", fetch_grant, 1);

    // R3 R4 R8 R9 R11: sweep over every vector
    for (int v = 0; v < 256; v++) begin
      logic [15:0] f, c, i, s, ss;
      f  = ({8'(v) ^ 8'h3C, 8'(v)} & ~16'h0300) | 16'h0200 | (v[0] ? 16'h0100 : 16'h0);
      c  = 16'(v * 257 + 1);
      i  = 16'(v * 73);
      s  = (v % 16 == 0) ? 16'h0000 : 16'(16'h8000 + v * 6);
      ss = (v % 7 == 0) ? 16'hFFFF : 16'(v * 16 + 256);
      run_entry(8'(v), f, c, i, s, ss, v % 3, (v % 32) == 5, "sweep");
    end

    // R5: vectors 0 and 2 bypass a clear enable bit
    run_entry(8'd0, 16'h0100, 16'hABCD, 16'h1234, 16'h0400, 16'h2000, 1, 1'b0, "R5 vec0");
    run_entry(8'd2, 16'h0001, 16'h0F0F, 16'h7777, 16'h0010, 16'h0000, 2, 1'b0, "R5 vec2");

    // R5 / R2: masked vector waits, later raise replaces it
    ss_i = 16'h3000; lat = 1;
    load_regs(16'h0000, 16'h5555, 16'h6666, 16'h1000);
    log_n = 0;
    raise(8'd7);
    raise(8'd9);
    busy = 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (mem_valid) busy++;
    end
    check(busy == 0, "R5 masked vector stays pending", busy, 0);
    check(fetch_grant === 1'b1, "R5 fetch granted while masked", fetch_grant, 1);
    load_regs(16'h0200, 16'h5555, 16'h6666, 16'h1000);
    wait_done(1'b0, ok);
    check(ok, "R5 entry after enable", ok, 1);
    if (ok) check_entry(8'd9, 16'h0200, 16'h5555, 16'h6666, 16'h1000, 16'h3000, "R2 R5 replaced vector");

    // R6: no second entry from one raise
    busy = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mem_valid) busy++;
    end
    check(busy == 0, "R6 pending cleared", busy, 0);

    check(stall_err == 0, "R9 request stable while stalled", stall_err, 0);
    check(grant_err == 0, "R10 no grant during entry", grant_err, 0);

    // R7: halt
    @(negedge clk);
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    raise(8'd0);
    busy = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mem_valid || fetch_grant) busy++;
    end
    check(halted === 1'b1, "R7 halted set", halted, 1);
    check(busy == 0, "R7 no entry or fetch while halted", busy, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule